// File: doc/BRIEF.md
# Gated-Input Serial-In Parallel-Out Shift Register

This block is a chain of flip-flop stages that shifts in one bit per rising clock edge and shows every stage on a parallel output bus. The bit that enters the chain is the logical AND of two serial inputs. Either input can therefore act as an enable for the other. Holding one input low forces zeros into the chain. Holding it high lets the other input's data through.

An active-low clear empties every stage at once, with no clock edge needed. While the clear is held low it takes priority over any clock edge. Between rising edges the stored word does not change, whatever the serial inputs do. The length of the chain is a parameter with a default of eight. Longer chains can be built by feeding the last output of one instance into a serial input of the next.

Top module: `gated_sipo_shifter`

## Requirements
- R1: While `rst_n` is low, every bit of `par_q` is 0, and it becomes 0 as soon as `rst_n` falls, without waiting for a clock edge.
- R2: A rising edge of `clk` while `rst_n` is low leaves `par_q` at all zeros, even with both serial inputs high.
- R3: On a rising edge with `rst_n` high, `par_q[0]` takes the value `ser_a AND ser_b` present at that edge.
- R4: If `ser_a` or `ser_b` (or both) is 0 at a rising edge, `par_q[0]` is 0 after that edge, whatever the other input is.
- R5: On a rising edge with `rst_n` high, `par_q[i]` takes the value `par_q[i-1]` held before the edge, for every i from 1 to WIDTH-1.
- R6: With `rst_n` high, changes on `ser_a` and `ser_b` between rising edges leave `par_q` unchanged. Only the values present at the edge are captured.
- R7: Bit 0 of `par_q` is the first stage and bit WIDTH-1 is the last: a single 1 shifted in reaches `par_q[WIDTH-1]` after exactly WIDTH edges.
- R8: When the last output of one instance drives `ser_a` of a second instance that has `ser_b` tied high, the pair acts as a single chain of twice the length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, active on the rising edge |
| rst_n | input | 1 | Asynchronous clear, active low |
| ser_a | input | 1 | Serial input, ANDed with ser_b |
| ser_b | input | 1 | Serial input, ANDed with ser_a |
| par_q | output | WIDTH | Stage outputs, bit 0 is the first stage |

## Verification
A wrong stage value shows up on `par_q` right after the edge that produced it. The bench compares the whole word after every edge, so a bad gating term or a broken link in the chain is caught within one cycle. A stuck bit in a later stage is caught once a known 1 has travelled that far, which takes at most WIDTH edges. A clear that depends on the clock, or that fails to take priority, shows up within a few nanoseconds of `rst_n` falling, because the bench asserts the clear away from the clock edges.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    // Entry bit of the chain: both serial inputs must be high to shift in a 1.
    function automatic logic gate_serial(input logic a, input logic b);
        return a & b;
    endfunction

endpackage

// File: rtl/sipo_serial_gate.sv
module sipo_serial_gate (
    input  logic ser_a,
    input  logic ser_b,
    output logic din
);

    always_comb begin
        din = sipo_pkg::gate_serial(ser_a, ser_b);
    end

endmodule

// File: rtl/sipo_shift_core.sv
module sipo_shift_core #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] stages;
    } core_t;

    core_t st_d;
    core_t st_q;

    generate
        if (WIDTH == 1) begin : g_single
            always_comb begin
                st_d        = st_q;
                st_d.stages = din;
            end
        end else begin : g_chain
            always_comb begin
                st_d        = st_q;
                st_d.stages = {st_q.stages[WIDTH-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.stages;

endmodule

// File: rtl/gated_sipo_shifter.sv
module gated_sipo_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_a,
    input  logic             ser_b,
    output logic [WIDTH-1:0] par_q
);

    logic entry_bit;

    sipo_serial_gate u_gate (
        .ser_a (ser_a),
        .ser_b (ser_b),
        .din   (entry_bit)
    );

    sipo_shift_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (entry_bit),
        .q     (par_q)
    );

endmodule

// File: rtl/gated_sipo_checker.sv
module gated_sipo_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ser_a,
    input logic             ser_b,
    input logic [WIDTH-1:0] par_q
);

    AST_CLEAR_HOLDS_ZERO: assert property (@(posedge clk)
        !rst_n |-> par_q == '0); // R1

    AST_ENTRY_IS_AND: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> par_q[0] == $past(ser_a && ser_b)); // R3

    AST_GATE_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_a && ser_b) |=> !par_q[0]); // R4

    generate
        if (WIDTH > 1) begin : g_link
            AST_STAGE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> par_q[WIDTH-1:1] == $past(par_q[WIDTH-2:0])); // R5
        end
    endgenerate

endmodule

bind gated_sipo_shifter gated_sipo_checker #(
    .WIDTH (WIDTH)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ser_a (ser_a),
    .ser_b (ser_b),
    .par_q (par_q)
);

// File: tb/test_gated_sipo_shifter.sv
module test_gated_sipo_shifter;

    localparam int W = 8;

    typedef struct {
        logic [W-1:0]   exp_main;
        logic [2*W-1:0] exp_cas;
        string          req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_a = 1'b0;
    logic         ser_b = 1'b0;
    logic [W-1:0] par_q;
    logic [W-1:0] lo_q;
    logic [W-1:0] hi_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0]   model_main = '0;
    logic [2*W-1:0] model_cas  = '0;
    item_t          sb_q[$];

    always #5 clk = ~clk;

    gated_sipo_shifter #(.WIDTH(W)) i_gated_sipo_shifter (
        .clk(clk), .rst_n(rst_n), .ser_a(ser_a), .ser_b(ser_b), .par_q(par_q)
    );

    // R8: two instances cascaded into one chain of 2*W stages
    gated_sipo_shifter #(.WIDTH(W)) i_cas_lo (
        .clk(clk), .rst_n(rst_n), .ser_a(ser_a), .ser_b(ser_b), .par_q(lo_q)
    );
    gated_sipo_shifter #(.WIDTH(W)) i_cas_hi (
        .clk(clk), .rst_n(rst_n), .ser_a(lo_q[W-1]), .ser_b(1'b1), .par_q(hi_q)
    );

    task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: sets inputs, waits for the edge, updates the reference, pushes the expectation.
    task automatic step(input logic a, input logic b, input string req);
        item_t it;
        ser_a = a;
        ser_b = b;
        @(posedge clk);
        #1;
        model_main  = {model_main[W-2:0], a & b};
        model_cas   = {model_cas[2*W-2:0], a & b};
        it.exp_main = model_main;
        it.exp_cas  = model_cas;
        it.req      = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compares one expectation per falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(it.req, {{W{1'b0}}, par_q}, {{W{1'b0}}, it.exp_main});
                check({it.req, "/R8"}, {hi_q, lo_q}, it.exp_cas);
            end
        end
    end

    // Clear asserted and released away from clock edges.
    task automatic async_clear(input int offset_ns);
        @(negedge clk);
        #(offset_ns);
        rst_n = 1'b0;
        #1;
        check("R1", {{W{1'b0}}, par_q}, '0);
        check("R1/R8", {hi_q, lo_q}, '0);
        ser_a = 1'b1;
        ser_b = 1'b1;
        @(posedge clk);
        #2;
        check("R2", {{W{1'b0}}, par_q}, '0);
        #5;
        rst_n = 1'b1;
        model_main = '0;
        model_cas  = '0;
        #1;
        check("R2", {{W{1'b0}}, par_q}, '0);
    endtask

    initial begin
        #3;
        check("R1", {{W{1'b0}}, par_q}, '0);
        #14 rst_n = 1'b1;

        // R3: data passes when both inputs high
        step(1'b1, 1'b1, "R3");
        step(1'b1, 1'b0, "R3");
        step(1'b1, 1'b1, "R3");
        step(1'b0, 1'b1, "R3");
        step(1'b1, 1'b1, "R3");
        // R4: each input alone gates zeros in
        step(1'b0, 1'b1, "R4");
        step(1'b1, 1'b0, "R4");
        step(1'b0, 1'b0, "R4");
        // R5: mixed pattern walks along the chain
        for (int i = 0; i < 2 * W; i++) begin
            step(((i * 5) % 3) != 0, (i % 4) != 1, "R5");
        end

        // R6: inputs toggle between edges with no effect
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            ser_a = k[0];
            ser_b = k[1];
            #1;
            check("R6", {{W{1'b0}}, par_q}, {{W{1'b0}}, model_main});
        end
        step(1'b0, 1'b1, "R6");

        async_clear(2);

        // R7: single 1 reaches the last stage after W edges
        step(1'b1, 1'b1, "R7");
        for (int i = 1; i < W; i++) begin
            step(1'b0, 1'b1, "R7");
        end
        @(negedge clk);
        #1;
        check("R7", {{(2*W-1){1'b0}}, par_q[W-1]}, 1);
        // R8: keep pushing it into the second instance
        for (int i = 0; i < W; i++) begin
            step(1'b1, 1'b0, "R8");
        end
        @(negedge clk);
        #1;
        check("R8", {{(2*W-1){1'b0}}, hi_q[W-1]}, 1);

        for (int i = 0; i < W; i++) begin
            step(1'b1, 1'b1, "R3");
        end
        async_clear(3);
        step(1'b1, 1'b1, "R3");
        step(1'b0, 1'b0, "R4");

        @(negedge clk);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule